// File: doc/BRIEF.md
# Address Table Load/Purge Engine

This block keeps a small table of forwarding entries. Each entry is keyed by a database number and a 48-bit MAC address. It carries a 4-bit entry state, a trunk flag, and a port vector (or trunk identifier). Software reaches the block through a 16-bit register interface. It stages the MAC address, the entry data and the database number, then writes a command into the operation register. The engine then walks the table one slot per clock cycle. It loads the entry into the slot that already holds the same key, or into the first empty slot. A state of zero turns the same command into a purge of the matching entry. A busy bit stays high for the whole command, and software polls it.

The database number comes from different register fields depending on how many databases the build supports. A wide build takes it from a dedicated 12-bit register. A middle-sized build joins a nibble of the control register to the low nibble of the operation register. A small build uses only that low nibble. The control register also holds an age-time code and a learn-to-all bit, which software can read back. A combinational query port lets the forwarding logic look up a key and read back the stored entry data.

Top module: `addr_table_engine`

## Requirements
- R1: Register 0 keeps only bits 11:0 of a write and reads back 15:12 as zero. When NUM_DB > 256, it alone supplies the database number of a command, and operation bits 3:0 are not used for it.
- R2: When 16 < NUM_DB <= 256, the command database number is {control[15:12], operation[3:0]}, with operation[3:0] taken from the starting write. When NUM_DB <= 16, it is operation[3:0] only. In both cases register 0 is not used.
- R3: Control register (address 1) bits 11:4 hold the age-time code, which resets to AGE_RESET. A control write whose bits 11:4 are zero leaves the code unchanged, so the code is never zero.
- R4: Control bit 3 is the learn-to-all bit. It is written and read back independently of the other control fields, and control bits 2:0 read as zero.
- R5: A write to the operation register (address 2) while idle stores bits 14:12 (opcode) and bits 3:0. Opcode 3 starts a load/purge and sets busy (operation bit 15 and the busy port). Other opcodes start nothing.
- R6: While busy is set, writes to the operation register are ignored: the stored opcode and low bits do not change and no command starts.
- R7: The data register (address 3) stores state in bits 3:0, the port vector in bits 4+NUM_PORTS-1:4, and the trunk flag in bit 15. All other bits read as zero. Loaded entries carry the same masked encoding on qry_data.
- R8: MAC registers at addresses 4, 5 and 6 hold bytes 0-1, 2-3 and 4-5, with the lower-numbered byte in bits 15:8. Byte 0 maps to bits 47:40 of the key and of qry_mac.
- R9: A load with a nonzero state overwrites the slot holding the same key. Otherwise it writes the lowest-numbered empty slot.
- R10: A load with state 0 invalidates the slot holding the key and leaves all other entries unchanged. If no slot holds the key, the table is unchanged.
- R11: A load with a nonzero state that finds neither a matching nor an empty slot sets the full-violation flag (operation bit 11 and full_viol). The flag stays set until an accepted operation write has bit 11 set.
- R12: The search examines one slot per cycle. Busy stays high for ENTRIES+1 cycles when no slot matches, and for i+2 cycles when slot i matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 dbnum, 1 control, 2 operation, 3 data, 4-6 MAC) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| busy | output | 1 | Command in progress |
| full_viol | output | 1 | Sticky table-full violation flag |
| qry_db | input | 12 | Query database number |
| qry_mac | input | 48 | Query MAC, byte 0 in bits 47:40 |
| qry_hit | output | 1 | A valid entry matches the query key |
| qry_data | output | 16 | Matching entry data in data-register encoding, zero on a miss |

## Verification
The bench builds two instances. The first uses the defaults: 16 slots, 4096 databases and 11 ports. Here the 12-bit database register is the key source, and the longer scan makes the busy lengths for a match in slot 0, a match in slot 1 and a full scan clearly different, which exposes first-free placement. The second uses 4 slots, 256 databases and 7 ports. In that build the split database number can be reached, the port-vector mask cuts off real bits, and the table fills after four loads, so the sticky full flag and how it is cleared can be exercised.

// File: rtl/addr_tbl_pkg.sv
package addr_tbl_pkg;

  localparam int PV_MAX = 11;

  localparam logic [2:0] A_DBN  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_OP   = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_MAC0 = 3'd4;

  localparam logic [2:0] OPC_LOAD = 3'd3;

  typedef struct packed {
    logic              valid;
    logic [11:0]       db;
    logic [47:0]       mac;
    logic              trunk;
    logic [PV_MAX-1:0] portv;
    logic [3:0]        state;
  } at_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} at_state_e;

endpackage

// File: rtl/at_regs.sv
module at_regs
  import addr_tbl_pkg::*;
#(
  parameter int          NUM_DB    = 4096,
  parameter int          NUM_PORTS = 11,
  parameter logic [7:0]  AGE_RESET = 8'd20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        busy,
  input  logic        full,
  output logic        start,
  output logic        clr_full,
  output logic [11:0] key_db,
  output logic [47:0] key_mac,
  output logic [15:0] key_data
);

  localparam logic [PV_MAX-1:0] PV_MASK   = PV_MAX'((32'd1 << NUM_PORTS) - 32'd1);
  localparam logic [15:0]       DATA_MASK = {1'b1, PV_MASK, 4'hF};

  logic [11:0]      dbn_q,  dbn_d;
  logic [3:0]       dbhi_q, dbhi_d;
  logic [7:0]       age_q,  age_d;
  logic             l2a_q,  l2a_d;
  logic [2:0]       opc_q,  opc_d;
  logic [3:0]       oplo_q, oplo_d;
  logic [15:0]      data_q, data_d;
  logic [2:0][15:0] mac_q,  mac_d;

  logic op_acc;
  assign op_acc   = we && (addr == A_OP) && !busy;
  assign start    = op_acc && (wdata[14:12] == OPC_LOAD);
  assign clr_full = op_acc && wdata[11];

  always_comb begin
    dbn_d  = dbn_q;
    dbhi_d = dbhi_q;
    age_d  = age_q;
    l2a_d  = l2a_q;
    opc_d  = opc_q;
    oplo_d = oplo_q;
    data_d = data_q;
    mac_d  = mac_q;
    if (we && addr == A_DBN) dbn_d = wdata[11:0];
    if (we && addr == A_CTRL) begin
      dbhi_d = wdata[15:12];
      l2a_d  = wdata[3];
      if (wdata[11:4] != 8'd0) age_d = wdata[11:4];
    end
    if (op_acc) begin
      opc_d  = wdata[14:12];
      oplo_d = wdata[3:0];
    end
    if (we && addr == A_DATA) data_d = wdata & DATA_MASK;
    for (int i = 0; i < 3; i++)
      if (we && addr == 3'(A_MAC0 + 3'(i))) mac_d[i] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbn_q  <= '0;
      dbhi_q <= '0;
      age_q  <= AGE_RESET;
      l2a_q  <= 1'b0;
      opc_q  <= '0;
      oplo_q <= '0;
      data_q <= '0;
      mac_q  <= '0;
    end else begin
      dbn_q  <= dbn_d;
      dbhi_q <= dbhi_d;
      age_q  <= age_d;
      l2a_q  <= l2a_d;
      opc_q  <= opc_d;
      oplo_q <= oplo_d;
      data_q <= data_d;
      mac_q  <= mac_d;
    end
  end

  generate
    if (NUM_DB > 256) begin : g_db_wide
      assign key_db = dbn_q;
    end else if (NUM_DB > 16) begin : g_db_mid
      assign key_db = {4'd0, dbhi_q, wdata[3:0]};
    end else begin : g_db_small
      assign key_db = {8'd0, wdata[3:0]};
    end
  endgenerate

  assign key_mac  = {mac_q[0], mac_q[1], mac_q[2]};
  assign key_data = data_q;

  always_comb begin
    case (addr)
      A_DBN:  rdata = {4'd0, dbn_q};
      A_CTRL: rdata = {dbhi_q, age_q, l2a_q, 3'd0};
      A_OP:   rdata = {busy, opc_q, full, 7'd0, oplo_q};
      A_DATA: rdata = data_q;
      3'd4:   rdata = mac_q[0];
      3'd5:   rdata = mac_q[1];
      3'd6:   rdata = mac_q[2];
      default: rdata = 16'd0;
    endcase
  end

  // R6: an operation write during busy leaves the stored fields alone
  assert_op_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && addr == A_OP) |=> ($stable(opc_q) && $stable(oplo_q)));

  // R3: the age-time code never becomes zero
  assert_age_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    age_q != 8'd0);

endmodule

// File: rtl/at_table.sv
module at_table
  import addr_tbl_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_valid,
  output logic [11:0]     rd_db,
  output logic [47:0]     rd_mac,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  at_entry_t       wr_entry,
  input  logic [11:0]     qry_db,
  input  logic [47:0]     qry_mac,
  output logic            qry_hit,
  output logic [15:0]     qry_data
);

  logic [ENTRIES-1:0] vld_q;
  at_entry_t          ent_q [ENTRIES];
  logic [ENTRIES-1:0] hit_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_entry.valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_idx] <= wr_entry;
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_db    = ent_q[rd_idx].db;
  assign rd_mac   = ent_q[rd_idx].mac;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_v[g] = vld_q[g] && (ent_q[g].db == qry_db) && (ent_q[g].mac == qry_mac);
    end
  endgenerate

  always_comb begin
    qry_data = 16'd0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_v[i]) qry_data = qry_data | {ent_q[i].trunk, ent_q[i].portv, ent_q[i].state};
  end
  assign qry_hit = |hit_v;

  // R10: a purge write leaves its slot empty
  assert_purge_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_entry.valid) |=> !vld_q[$past(wr_idx)]);

  // R9: at most one slot ever matches a given key
  assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_v));

endmodule

// File: rtl/at_ctrl.sv
module at_ctrl
  import addr_tbl_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            clr_full,
  input  logic [11:0]     key_db,
  input  logic [47:0]     key_mac,
  input  logic [15:0]     key_data,
  output logic [IDXW-1:0] rd_idx,
  input  logic            rd_valid,
  input  logic [11:0]     rd_db,
  input  logic [47:0]     rd_mac,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output at_entry_t       wr_entry,
  output logic            busy,
  output logic            full
);

  localparam logic [IDXW-1:0] LAST = IDXW'(ENTRIES - 1);

  at_state_e       st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d, hidx_q, hidx_d, fidx_q, fidx_d;
  logic            hit_q, hit_d, free_q, free_d, full_q, full_d;
  logic [11:0]     cdb_q, cdb_d;
  logic [47:0]     cmac_q, cmac_d;
  logic [15:0]     cdat_q, cdat_d;
  logic            match, purge;

  assign match = rd_valid && (rd_db == cdb_q) && (rd_mac == cmac_q);
  assign purge = (cdat_q[3:0] == 4'd0);

  always_comb begin
    st_d = st_q; idx_d = idx_q; hidx_d = hidx_q; fidx_d = fidx_q;
    hit_d = hit_q; free_d = free_q; full_d = full_q;
    cdb_d = cdb_q; cmac_d = cmac_q; cdat_d = cdat_q;
    wr_en = 1'b0;
    wr_idx = hidx_q;
    wr_entry = '{valid: !purge, db: cdb_q, mac: cmac_q, trunk: cdat_q[15],
                 portv: cdat_q[14:4], state: cdat_q[3:0]};
    if (clr_full) full_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_SCAN; idx_d = '0; hit_d = 1'b0; free_d = 1'b0;
        cdb_d = key_db; cmac_d = key_mac; cdat_d = key_data;
      end
      ST_SCAN: begin
        if (match) begin
          hit_d = 1'b1; hidx_d = idx_q; st_d = ST_FIN;
        end else begin
          if (!rd_valid && !free_q) begin
            free_d = 1'b1; fidx_d = idx_q;
          end
          if (idx_q == LAST) st_d = ST_FIN;
          else idx_d = idx_q + 1'b1;
        end
      end
      ST_FIN: begin
        st_d = ST_IDLE;
        if (hit_q) wr_en = 1'b1;
        else if (!purge && free_q) begin
          wr_en = 1'b1; wr_idx = fidx_q;
        end else if (!purge) full_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; hidx_q <= '0; fidx_q <= '0;
      hit_q <= 1'b0; free_q <= 1'b0; full_q <= 1'b0;
      cdb_q <= '0; cmac_q <= '0; cdat_q <= '0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; hidx_q <= hidx_d; fidx_q <= fidx_d;
      hit_q <= hit_d; free_q <= free_d; full_q <= full_d;
      cdb_q <= cdb_d; cmac_q <= cmac_d; cdat_q <= cdat_d;
    end
  end

  assign rd_idx = idx_q;
  assign busy   = (st_q != ST_IDLE);
  assign full   = full_q;

  // R5: busy only rises after an accepted load/purge command
  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R12: busy drops in the cycle after the finishing step
  assert_fin_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIN) |=> !busy);

  // R11: the violation flag holds until cleared
  assert_full_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr_full) |=> full);

endmodule

// File: rtl/addr_table_engine.sv
module addr_table_engine
  import addr_tbl_pkg::*;
#(
  parameter int         ENTRIES   = 16,
  parameter int         NUM_DB    = 4096,
  parameter int         NUM_PORTS = 11,
  parameter logic [7:0] AGE_RESET = 8'd20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy,
  output logic        full_viol,
  input  logic [11:0] qry_db,
  input  logic [47:0] qry_mac,
  output logic        qry_hit,
  output logic [15:0] qry_data
);

  localparam int IDXW = $clog2(ENTRIES);

  logic            rst_meta, rst_sync;
  logic            start, clr_full;
  logic [11:0]     key_db, rd_db;
  logic [47:0]     key_mac, rd_mac;
  logic [15:0]     key_data;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic            rd_valid, wr_en;
  at_entry_t       wr_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  at_regs #(.NUM_DB(NUM_DB), .NUM_PORTS(NUM_PORTS), .AGE_RESET(AGE_RESET)) u_regs (
    .clk(clk), .rst_n(rst_sync), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .full(full_viol), .start(start),
    .clr_full(clr_full), .key_db(key_db), .key_mac(key_mac), .key_data(key_data)
  );

  at_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .start(start), .clr_full(clr_full),
    .key_db(key_db), .key_mac(key_mac), .key_data(key_data),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_db(rd_db), .rd_mac(rd_mac),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .busy(busy), .full(full_viol)
  );

  at_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_sync), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_db(rd_db), .rd_mac(rd_mac), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_entry(wr_entry), .qry_db(qry_db), .qry_mac(qry_mac),
    .qry_hit(qry_hit), .qry_data(qry_data)
  );

endmodule

// File: tb/tb_addr_table_engine.sv
module tb_addr_table_engine;
  import addr_tbl_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        we_b = 0, we_s = 0;
  logic [2:0]  ad_b = 0, ad_s = 0;
  logic [15:0] wd_b = 0, wd_s = 0, rd_b, rd_s;
  logic        busy_b, busy_s, full_b, full_s, hit_b, hit_s;
  logic [11:0] qdb_b = 0, qdb_s = 0;
  logic [47:0] qm_b = 0, qm_s = 0;
  logic [15:0] qd_b, qd_s;

  int checks = 0, errors = 0;

  addr_table_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we_b), .reg_addr(ad_b), .reg_wdata(wd_b),
    .reg_rdata(rd_b), .busy(busy_b), .full_viol(full_b), .qry_db(qdb_b),
    .qry_mac(qm_b), .qry_hit(hit_b), .qry_data(qd_b));

  addr_table_engine #(.ENTRIES(4), .NUM_DB(256), .NUM_PORTS(7)) dut_s (
    .clk(clk), .rst_n(rst_n), .reg_we(we_s), .reg_addr(ad_s), .reg_wdata(wd_s),
    .reg_rdata(rd_s), .busy(busy_s), .full_viol(full_s), .qry_db(qdb_s),
    .qry_mac(qm_s), .qry_hit(hit_s), .qry_data(qd_s));

  // {addr, write data, expected readback} on the default instance
  localparam logic [34:0] VEC [9] = '{
    {3'd0, 16'hF123, 16'h0123},
    {3'd1, 16'hA5FF, 16'hA5F8},
    {3'd1, 16'h3008, 16'h35F8},
    {3'd1, 16'h0017, 16'h0010},
    {3'd3, 16'hBEEF, 16'hBEEF},
    {3'd4, 16'h0102, 16'h0102},
    {3'd6, 16'hA0B1, 16'hA0B1},
    {3'd2, 16'h0005, 16'h0005},
    {3'd7, 16'hFFFF, 16'h0000}
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R1";
      1: return "R4";
      2: return "R3";
      3: return "R4";
      4: return "R7";
      5, 6: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(bit s, logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    if (s) begin we_s = 1; ad_s = a; wd_s = d; end
    else   begin we_b = 1; ad_b = a; wd_b = d; end
    @(negedge clk);
    we_s = 0; we_b = 0;
  endtask

  task automatic rd(bit s, logic [2:0] a, output logic [15:0] v);
    if (s) ad_s = a; else ad_b = a;
    #1;
    v = s ? rd_s : rd_b;
  endtask

  task automatic run_op(bit s, logic [15:0] d, output int cyc);
    wr(s, 3'd2, d);
    cyc = 0;
    while (s ? busy_s : busy_b) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic qry(bit s, logic [11:0] db, logic [47:0] m, output logic h, output logic [15:0] d);
    if (s) begin qdb_s = db; qm_s = m; end
    else   begin qdb_b = db; qm_b = m; end
    #1;
    h = s ? hit_s : hit_b;
    d = s ? qd_s : qd_b;
  endtask

  task automatic set_mac(bit s, logic [15:0] m0, logic [15:0] m1, logic [15:0] m2);
    wr(s, 3'd4, m0);
    wr(s, 3'd5, m1);
    wr(s, 3'd6, m2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, d;
    logic h;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // reset state
    rd(0, 3'd0, v); chk("R1 reset dbn", v, 16'h0000);
    rd(0, 3'd1, v); chk("R3 reset control", v, 16'h0140);
    rd(0, 3'd2, v); chk("R5 reset op", v, 16'h0000);
    rd(0, 3'd3, v); chk("R7 reset data", v, 16'h0000);
    chk("R11 reset full", full_b, 0);
    chk("R5 reset busy", busy_b, 0);

    // register file vectors
    for (int i = 0; i < 9; i++) begin
      wr(0, VEC[i][34:32], VEC[i][31:16]);
      rd(0, VEC[i][34:32], v);
      chk(vec_req(i), v, VEC[i][15:0]);
    end
    chk("R5 non-load opcode no busy", busy_b, 0);

    // load A: db from register 0 (0x123); op low bits 5 ignored
    set_mac(0, 16'h0011, 16'h2233, 16'h4455);
    wr(0, 3'd3, 16'h8125);
    run_op(0, 16'h3005, cyc);
    chk("R12 busy full scan", cyc, 17);
    qry(0, 12'h123, 48'h001122334455, h, d);
    chk("R9 load A hit", h, 1); chk("R9 load A data", d, 16'h8125);
    qry(0, 12'h005, 48'h001122334455, h, d);
    chk("R1 low nibble not used", h, 0);
    qry(0, 12'h124, 48'h001122334455, h, d);
    chk("R1 other db miss", h, 0);

    // load B to slot 1
    wr(0, 3'd6, 16'h4466);
    wr(0, 3'd3, 16'h0F17);
    run_op(0, 16'h3000, cyc);
    chk("R12 busy B", cyc, 17);
    qry(0, 12'h123, 48'h001122334466, h, d);
    chk("R8 B data", d, 16'h0F17);

    // reload A: match at slot 0
    wr(0, 3'd6, 16'h4455);
    wr(0, 3'd3, 16'h0043);
    run_op(0, 16'h3000, cyc);
    chk("R12 match slot0 busy", cyc, 2);
    qry(0, 12'h123, 48'h001122334455, h, d);
    chk("R9 overwrite A", d, 16'h0043);

    // R6: operation write during busy ignored
    wr(0, 3'd6, 16'h4466);
    wr(0, 3'd3, 16'h0F17);
    wr(0, 3'd2, 16'h3000);
    wr(0, 3'd2, 16'h1009);
    while (busy_b) @(negedge clk);
    rd(0, 3'd2, v);
    chk("R6 op held", v, 16'h3000);
    @(negedge clk);
    chk("R6 no new command", busy_b, 0);

    // purge A
    wr(0, 3'd6, 16'h4455);
    wr(0, 3'd3, 16'h0FF0);
    run_op(0, 16'h3000, cyc);
    chk("R12 purge match busy", cyc, 2);
    qry(0, 12'h123, 48'h001122334455, h, d);
    chk("R10 A purged", h, 0);
    qry(0, 12'h123, 48'h001122334466, h, d);
    chk("R10 B kept", {15'd0, h, d}, {15'd0, 1'b1, 16'h0F17});

    // purge of absent key
    wr(0, 3'd6, 16'h4477);
    run_op(0, 16'h3000, cyc);
    chk("R10 absent purge scan", cyc, 17);
    qry(0, 12'h123, 48'h001122334466, h, d);
    chk("R10 absent purge no effect", h, 1);

    // load C takes first free slot (slot 0)
    wr(0, 3'd6, 16'h4488);
    wr(0, 3'd3, 16'h0001);
    run_op(0, 16'h3000, cyc);
    chk("R9 C load scan", cyc, 17);
    run_op(0, 16'h3000, cyc);
    chk("R9 C in first free slot", cyc, 2);
    qry(0, 12'h123, 48'h001122334488, h, d);
    chk("R9 C hit", h, 1);

    // non-load opcode starts nothing
    wr(0, 3'd2, 16'h2000);
    chk("R5 opcode 2 idle", busy_b, 0);

    // small instance: mask, split db number, full
    wr(1, 3'd3, 16'hFFFF);
    rd(1, 3'd3, v);
    chk("R7 port mask", v, 16'h87FF);
    wr(1, 3'd0, 16'h0777);
    wr(1, 3'd1, 16'hA140);
    set_mac(1, 16'h0000, 16'h0000, 16'h0001);
    wr(1, 3'd3, 16'hFFF2);
    run_op(1, 16'h3005, cyc);
    chk("R12 small scan busy", cyc, 5);
    qry(1, 12'h0A5, 48'h1, h, d);
    chk("R2 split db hit", h, 1);
    chk("R7 masked entry data", d, 16'h87F2);
    qry(1, 12'h777, 48'h1, h, d);
    chk("R2 register 0 unused", h, 0);
    for (int k = 2; k <= 4; k++) begin
      wr(1, 3'd6, 16'(k));
      run_op(1, 16'h3005, cyc);
    end
    chk("R11 no full after 4", full_s, 0);
    wr(1, 3'd6, 16'h0005);
    run_op(1, 16'h3005, cyc);
    chk("R11 full scan", cyc, 5);
    rd(1, 3'd2, v);
    chk("R11 full in op", v, 16'h3805);
    qry(1, 12'h0A5, 48'h5, h, d);
    chk("R11 not stored", h, 0);
    wr(1, 3'd2, 16'h0005);
    rd(1, 3'd2, v);
    chk("R11 sticky", v, 16'h0805);
    wr(1, 3'd2, 16'h0805);
    rd(1, 3'd2, v);
    chk("R11 cleared", v, 16'h0005);
    chk("R11 port cleared", full_s, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule